// File: doc/BRIEF.md
# Unified GPR and CSR Register File

This block stores a processor's general-purpose registers and four machine CSRs in one RAM array. One index space covers both kinds of entry. The GPRs take the low indices and the CSR slots follow directly after the last GPR. A parameter selects the GPR count: 32 registers by default, or a reduced set of 16. The CSR slot indices and the size of the array follow from that choice. With CSRs enabled, the internal address is 6 bits wide in full mode (36 entries used) and 5 bits wide in reduced mode (20 entries used). With CSRs disabled, the reduced array needs only 4 address bits.

Each access moves one 32-bit word. There are two synchronous read ports, one for rs1 and one for rs2, and a single write port. The write port is shared by the rd write and the CSR write. A CSR read takes over the rs1 port. Register x0 always reads as zero and cannot be written. No control state machine is involved. The only sequential elements are the storage array and the two registered read outputs, and their behaviour is set entirely by the per-cycle controls.

Top module: `rfu_regfile`

## Requirements
- R1: With `REDUCED` = 0 (the default) there are 32 independent GPRs, x0 to x31, selected by the full 5-bit index on `rs1_idx`, `rs2_idx` and `rd_idx`.
- R2: Reads are synchronous. The index sampled at a rising clock edge determines the read data, which appears on `rs1_data`/`rs2_data` after that edge and holds until the next edge.
- R3: Index 0 reads as zero on either port. A write with `rd_idx` = 0 is discarded.
- R4: With `REDUCED` = 1 there are 16 GPRs, and bit 4 of `rs1_idx`, `rs2_idx` and `rd_idx` is ignored. Index 16+n therefore reaches xn, and index 16 behaves as x0.
- R5: With `WITH_CSR` = 1 there are four CSR slots, selected by a 2-bit code: 0 scratch, 1 trap vector, 2 exception PC, 3 trap value. The slots sit at internal addresses GPR count + code. `csr_we` writes `wr_data` to the slot named by `csr_wsel`. When `csr_rd_en` is high, `rs1_data` returns the slot named by `csr_rsel` instead of the register named by `rs1_idx`. No GPR index reaches a CSR slot.
- R6: When `csr_we` and `rd_we` are both high in one cycle, only the CSR write takes effect and the GPR keeps its value.
- R7: A read sampled at the same edge as a write to the same location returns the previous contents. A read sampled at the following edge returns the new value.
- R8: While `rst_n` is low, both read outputs are zero and all writes are ignored. Stored contents survive reset.
- R9: With `WITH_CSR` = 0, `csr_rd_en`, `csr_rsel`, `csr_we` and `csr_wsel` have no effect. `rs1_data` follows `rs1_idx`, an `rd_we` write proceeds, and the array holds only the GPR count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the read registers; blocks writes |
| rs1_idx | input | 5 | First read port register index |
| rs2_idx | input | 5 | Second read port register index |
| csr_rd_en | input | 1 | Route a CSR slot to the first read port |
| csr_rsel | input | 2 | CSR slot to read (0 scratch, 1 vector, 2 exception PC, 3 trap value) |
| rs1_data | output | 32 | First read port data, registered |
| rs2_data | output | 32 | Second read port data, registered |
| rd_we | input | 1 | GPR write enable |
| rd_idx | input | 5 | GPR write index |
| csr_we | input | 1 | CSR write enable, takes priority over rd_we |
| csr_wsel | input | 2 | CSR slot to write |
| wr_data | input | 32 | Write data for GPR or CSR |

## Verification
The hardest situation to reach from the ports is an alias that stays hidden. In reduced mode, x16 to x31 silently land on x0 to x15, and a CSR slot must stay clear of every GPR index. A bench that writes and reads the same index never notices either problem. The bench therefore drives one stimulus stream into three instances at once (full with CSRs, reduced with CSRs, reduced without CSRs). It fills all 32 indices with distinct values and then reads low indices, so aliased writes show up as later values in the reduced instances. It also reads GPR indices 16 to 19 after the CSR slots have been written, and it issues a combined CSR and rd write, which the CSR-less instance must turn into a plain GPR write.

// File: rtl/rfu_pkg.sv
package rfu_pkg;

    localparam int CSR_SLOTS = 4;
    localparam int IDX_W     = 5;

    typedef enum logic [1:0] {
        CSR_SCRATCH = 2'd0,
        CSR_VECTOR  = 2'd1,
        CSR_EPC     = 2'd2,
        CSR_TVALUE  = 2'd3
    } csr_slot_e;

endpackage

// File: rtl/rfu_addr_map.sv
module rfu_addr_map
    import rfu_pkg::*;
#(
    parameter int GPR_N    = 32,
    parameter bit WITH_CSR = 1'b1,
    parameter int AW       = 6
) (
    input  logic [IDX_W-1:0] gpr_idx,
    input  logic             csr_en,
    input  csr_slot_e        csr_sel,
    output logic [AW-1:0]    addr,
    output logic             is_zero
);

    localparam int GW = $clog2(GPR_N);

    if (WITH_CSR) begin : g_csr
        localparam logic [AW-1:0] CSR_BASE = AW'(GPR_N);
        always_comb begin
            addr          = '0;
            addr[GW-1:0]  = gpr_idx[GW-1:0];
            is_zero       = (gpr_idx[GW-1:0] == '0);
            if (csr_en) begin
                addr    = CSR_BASE + AW'(csr_sel);
                is_zero = 1'b0;
            end
        end
    end else begin : g_gpr
        always_comb begin
            addr         = '0;
            addr[GW-1:0] = gpr_idx[GW-1:0];
            is_zero      = (gpr_idx[GW-1:0] == '0);
        end
    end

endmodule

// File: rtl/rfu_ram.sv
module rfu_ram #(
    parameter int DEPTH = 64,
    parameter int AW    = 6,
    parameter int DW    = 32,
    parameter int RP    = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [RP-1:0][AW-1:0]  rd_addr,
    input  logic [RP-1:0]          rd_zero,
    output logic [RP-1:0][DW-1:0]  rd_q,
    input  logic                   we,
    input  logic [AW-1:0]          wr_addr,
    input  logic [DW-1:0]          wr_data
);

    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[wr_addr] <= wr_data;
        end
    end

    for (genvar p = 0; p < RP; p++) begin : g_rd
        logic [DW-1:0] q_r;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q_r <= '0;
            end else begin
                q_r <= rd_zero[p] ? '0 : store[rd_addr[p]];
            end
        end
        assign rd_q[p] = q_r;
    end

endmodule

// File: rtl/rfu_regfile.sv
module rfu_regfile
    import rfu_pkg::*;
#(
    parameter bit REDUCED  = 1'b0,
    parameter bit WITH_CSR = 1'b1,
    parameter int DW       = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rs1_idx,
    input  logic [IDX_W-1:0] rs2_idx,
    input  logic             csr_rd_en,
    input  logic [1:0]       csr_rsel,
    output logic [DW-1:0]    rs1_data,
    output logic [DW-1:0]    rs2_data,
    input  logic             rd_we,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic             csr_we,
    input  logic [1:0]       csr_wsel,
    input  logic [DW-1:0]    wr_data
);

    localparam int GPR_N  = REDUCED ? 16 : 32;
    localparam int SLOT_N = WITH_CSR ? CSR_SLOTS : 0;
    localparam int AW     = $clog2(GPR_N + SLOT_N);
    localparam int DEPTH  = 1 << AW;

    logic [1:0][AW-1:0] raddr;
    logic [1:0]         rzero;
    logic [1:0][DW-1:0] rq;
    logic [AW-1:0]      waddr;
    logic               wzero;
    logic               csr_w;
    logic               wen;

    rfu_addr_map #(.GPR_N(GPR_N), .WITH_CSR(WITH_CSR), .AW(AW)) u_map_rs1 (
        .gpr_idx (rs1_idx),
        .csr_en  (csr_rd_en),
        .csr_sel (csr_slot_e'(csr_rsel)),
        .addr    (raddr[0]),
        .is_zero (rzero[0])
    );

    rfu_addr_map #(.GPR_N(GPR_N), .WITH_CSR(WITH_CSR), .AW(AW)) u_map_rs2 (
        .gpr_idx (rs2_idx),
        .csr_en  (1'b0),
        .csr_sel (CSR_SCRATCH),
        .addr    (raddr[1]),
        .is_zero (rzero[1])
    );

    rfu_addr_map #(.GPR_N(GPR_N), .WITH_CSR(WITH_CSR), .AW(AW)) u_map_wr (
        .gpr_idx (rd_idx),
        .csr_en  (csr_we),
        .csr_sel (csr_slot_e'(csr_wsel)),
        .addr    (waddr),
        .is_zero (wzero)
    );

    assign csr_w = WITH_CSR && csr_we;
    assign wen   = rst_n && (csr_w || (rd_we && !wzero));

    rfu_ram #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .RP(2)) u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (raddr),
        .rd_zero (rzero),
        .rd_q    (rq),
        .we      (wen),
        .wr_addr (waddr),
        .wr_data (wr_data)
    );

    assign rs1_data = rq[0];
    assign rs2_data = rq[1];

endmodule

// File: rtl/rfu_regfile_chk.sv
module rfu_regfile_chk #(
    parameter bit REDUCED  = 1'b0,
    parameter bit WITH_CSR = 1'b1,
    parameter int DW       = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic [4:0]    rs1_idx,
    input logic [4:0]    rs2_idx,
    input logic          csr_rd_en,
    input logic [1:0]    csr_rsel,
    input logic [DW-1:0] rs1_data,
    input logic [DW-1:0] rs2_data,
    input logic          rd_we,
    input logic [4:0]    rd_idx,
    input logic          csr_we,
    input logic [1:0]    csr_wsel,
    input logic [DW-1:0] wr_data
);

    localparam int GW = REDUCED ? 4 : 5;

    logic          live;
    logic          gv, gpend, cv, cpend;
    logic [GW-1:0] gidx;
    logic [1:0]    csel;
    logic [DW-1:0] gdat, gexp, cdat, cexp;
    logic          seen = 1'b0;
    logic          rst_was_low = 1'b0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live  <= 1'b0;
            gv    <= 1'b0;
            gpend <= 1'b0;
            cv    <= 1'b0;
            cpend <= 1'b0;
            gidx  <= '0;
            csel  <= '0;
            gdat  <= '0;
            gexp  <= '0;
            cdat  <= '0;
            cexp  <= '0;
        end else begin
            live  <= 1'b1;
            gv    <= rd_we && !(WITH_CSR && csr_we) && (rd_idx[GW-1:0] != '0);
            gidx  <= rd_idx[GW-1:0];
            gdat  <= wr_data;
            gpend <= gv && (rs2_idx[GW-1:0] == gidx);
            gexp  <= gdat;
            cv    <= WITH_CSR && csr_we;
            csel  <= csr_wsel;
            cdat  <= wr_data;
            cpend <= cv && csr_rd_en && (csr_rsel == csel);
            cexp  <= cdat;
        end
    end

    always @(posedge clk) begin
        seen        <= 1'b1;
        rst_was_low <= !rst_n;
        if (seen && rst_was_low) begin
            a_reset_clear_r8: assert (rs1_data == '0 && rs2_data == '0)
                else $error("read outputs not cleared during reset");
        end
    end

    p_x0_rs2_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        live && $past(rs2_idx[GW-1:0] == '0) |-> rs2_data == '0);

    p_x0_rs1_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        live && $past(rs1_idx[GW-1:0] == '0 && !(WITH_CSR && csr_rd_en)) |-> rs1_data == '0);

    p_gpr_readback_r7: assert property (@(posedge clk) disable iff (!rst_n)
        gpend |-> rs2_data == gexp);

    p_csr_readback_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cpend |-> rs1_data == cexp);

endmodule

bind rfu_regfile rfu_regfile_chk #(.REDUCED(REDUCED), .WITH_CSR(WITH_CSR), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rs1_idx   (rs1_idx),
    .rs2_idx   (rs2_idx),
    .csr_rd_en (csr_rd_en),
    .csr_rsel  (csr_rsel),
    .rs1_data  (rs1_data),
    .rs2_data  (rs2_data),
    .rd_we     (rd_we),
    .rd_idx    (rd_idx),
    .csr_we    (csr_we),
    .csr_wsel  (csr_wsel),
    .wr_data   (wr_data)
);

// File: tb/rfu_regfile_test.sv
`timescale 1ns/1ps

module rfu_model #(
    parameter bit REDUCED  = 1'b0,
    parameter bit WITH_CSR = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [4:0]  rs1_idx,
    input  logic [4:0]  rs2_idx,
    input  logic        csr_rd_en,
    input  logic [1:0]  csr_rsel,
    input  logic        rd_we,
    input  logic [4:0]  rd_idx,
    input  logic        csr_we,
    input  logic [1:0]  csr_wsel,
    input  logic [31:0] wr_data,
    output logic [31:0] exp_a,
    output logic [31:0] exp_b,
    output bit          kn_a,
    output bit          kn_b
);
    int          ngpr;
    logic [31:0] gpr [32];
    bit          gk  [32];
    logic [31:0] csr [4];
    bit          ck  [4];

    initial begin
        ngpr = REDUCED ? 16 : 32;
        foreach (gk[i]) gk[i] = 0;
        foreach (ck[i]) ck[i] = 0;
        exp_a = 0; exp_b = 0; kn_a = 0; kn_b = 0;
    end

    always @(posedge clk) begin
        int ga, gb, gw;
        if (!rst_n) begin
            exp_a <= 0; exp_b <= 0; kn_a <= 1; kn_b <= 1;
        end else begin
            ga = int'(rs1_idx) % ngpr;
            gb = int'(rs2_idx) % ngpr;
            if (WITH_CSR && csr_rd_en) begin
                exp_a <= csr[csr_rsel]; kn_a <= ck[csr_rsel];
            end else if (ga == 0) begin
                exp_a <= 0; kn_a <= 1;
            end else begin
                exp_a <= gpr[ga]; kn_a <= gk[ga];
            end
            if (gb == 0) begin
                exp_b <= 0; kn_b <= 1;
            end else begin
                exp_b <= gpr[gb]; kn_b <= gk[gb];
            end
            if (WITH_CSR && csr_we) begin
                csr[csr_wsel] = wr_data; ck[csr_wsel] = 1;
            end else if (rd_we) begin
                gw = int'(rd_idx) % ngpr;
                if (gw != 0) begin gpr[gw] = wr_data; gk[gw] = 1; end
            end
        end
    end
endmodule

module rfu_regfile_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  rs1_idx = '0, rs2_idx = '0, rd_idx = '0;
    logic        csr_rd_en = 1'b0, rd_we = 1'b0, csr_we = 1'b0;
    logic [1:0]  csr_rsel = '0, csr_wsel = '0;
    logic [31:0] wr_data = '0;

    logic [31:0] a_full, b_full, a_red, b_red, a_none, b_none;
    logic [31:0] ea_f, eb_f, ea_r, eb_r, ea_n, eb_n;
    bit          ka_f, kb_f, ka_r, kb_r, ka_n, kb_n;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string tag = "R8";

    always #2.5 clk = ~clk;

    rfu_regfile uut (.*, .rs1_data(a_full), .rs2_data(b_full));
    rfu_regfile #(.REDUCED(1'b1)) uut_e (.*, .rs1_data(a_red), .rs2_data(b_red));
    rfu_regfile #(.REDUCED(1'b1), .WITH_CSR(1'b0)) uut_n (.*, .rs1_data(a_none), .rs2_data(b_none));

    rfu_model m_f (.*, .exp_a(ea_f), .exp_b(eb_f), .kn_a(ka_f), .kn_b(kb_f));
    rfu_model #(.REDUCED(1'b1)) m_r (.*, .exp_a(ea_r), .exp_b(eb_r), .kn_a(ka_r), .kn_b(kb_r));
    rfu_model #(.REDUCED(1'b1), .WITH_CSR(1'b0)) m_n (.*, .exp_a(ea_n), .exp_b(eb_n), .kn_a(ka_n), .kn_b(kb_n));

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (ka_f) check(tag, "full rs1", a_full, ea_f);
        if (kb_f) check(tag, "full rs2", b_full, eb_f);
        if (ka_r) check(tag, "reduced rs1", a_red, ea_r);
        if (kb_r) check(tag, "reduced rs2", b_red, eb_r);
        if (ka_n) check(tag, "nocsr rs1", a_none, ea_n);
        if (kb_n) check(tag, "nocsr rs2", b_none, eb_n);
    end

    function automatic logic [31:0] val(int i);
        return {16'hA5A5, 16'(i * 7 + 1)};
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic idle();
        rd_we = 0; csr_we = 0; csr_rd_en = 0;
    endtask

    task automatic wr_gpr(int idx, logic [31:0] d);
        tick(); idle(); rd_we = 1; rd_idx = 5'(idx); wr_data = d;
    endtask

    task automatic wr_csr(int sel, logic [31:0] d);
        tick(); idle(); csr_we = 1; csr_wsel = 2'(sel); wr_data = d;
    endtask

    task automatic rd(int a, int b);
        tick(); idle(); rs1_idx = 5'(a); rs2_idx = 5'(b);
    endtask

    task automatic rd_csr(int sel, int a, int b);
        tick(); idle(); csr_rd_en = 1; csr_rsel = 2'(sel); rs1_idx = 5'(a); rs2_idx = 5'(b);
    endtask

    initial begin
        repeat (3) tick();
        check("R8", "full rs1 in reset", a_full, 0);
        check("R8", "full rs2 in reset", b_full, 0);
        check("R8", "reduced rs1 in reset", a_red, 0);
        check("R8", "nocsr rs2 in reset", b_none, 0);
        rst_n = 1;

        tag = "R1";
        for (int i = 1; i < 32; i++) wr_gpr(i, val(i));
        for (int i = 0; i < 32; i++) rd(i, 31 - i);
        rd(4, 31); tick();
        check("R1", "full x4", a_full, val(4));
        check("R4", "reduced x4 aliased by x20", a_red, val(20));
        check("R1", "full x31", b_full, val(31));
        check("R4", "reduced x31 is x15", b_red, val(31));

        tag = "R3";
        idle();
        wr_gpr(0, 32'hDEAD_BEEF);
        wr_gpr(16, 32'h1234_5678);
        rd(0, 16); tick();
        check("R3", "full x0 after write", a_full, 0);
        check("R3", "reduced x0 after write", a_red, 0);
        check("R1", "full x16", b_full, 32'h1234_5678);
        check("R4", "reduced x16 is x0", b_red, 0);

        tag = "R2";
        wr_gpr(5, 32'h5555_0005);
        rd(5, 5); tick();
        check("R2", "full x5 one cycle after read", a_full, 32'h5555_0005);
        for (int i = 1; i < 6; i++) rd(i, i + 8);

        tag = "R7";
        tick(); idle(); rd_we = 1; rd_idx = 7; wr_data = 32'h7777_0007; rs1_idx = 7;
        tick(); idle(); rs1_idx = 7;
        check("R7", "read at write edge is old", a_full, val(7));
        tick();
        check("R7", "read next edge is new", a_full, 32'h7777_0007);

        tag = "R5";
        for (int s = 0; s < 4; s++) wr_csr(s, 32'hC5C0_0000 + 32'(s));
        for (int s = 0; s < 4; s++) rd_csr(s, 2, 16 + s);
        rd_csr(1, 2, 16); tick();
        check("R5", "full vector slot", a_full, 32'hC5C0_0001);
        check("R5", "full x16 not aliased by slot", b_full, 32'h1234_5678);
        check("R5", "reduced vector slot", a_red, 32'hC5C0_0001);
        check("R9", "nocsr rs1 ignores csr_rd_en", a_none, val(18));

        tag = "R6";
        tick(); idle(); csr_we = 1; csr_wsel = 2; rd_we = 1; rd_idx = 9; wr_data = 32'h6666_0006;
        rd_csr(2, 3, 9); tick();
        check("R6", "full exception PC slot", a_full, 32'h6666_0006);
        check("R6", "full x9 keeps value", b_full, val(9));
        check("R9", "nocsr x9 takes rd write", b_none, 32'h6666_0006);

        tag = "R2";
        for (int n = 0; n < 4000; n++) begin
            tick();
            rs1_idx   = 5'($urandom);
            rs2_idx   = 5'($urandom);
            rd_idx    = 5'($urandom);
            rd_we     = ($urandom % 3) != 0;
            csr_we    = ($urandom % 5) == 0;
            csr_rd_en = ($urandom % 4) == 0;
            csr_rsel  = 2'($urandom);
            csr_wsel  = 2'($urandom);
            wr_data   = $urandom;
        end

        tag = "R8";
        tick(); rst_n = 0; idle(); rd_we = 1; rd_idx = 3; wr_data = 32'hFFFF_0BAD;
        csr_we = 1; csr_wsel = 0;
        tick(); tick();
        check("R8", "full rs1 zero in reset", a_full, 0);
        check("R8", "reduced rs2 zero in reset", b_red, 0);
        tick(); rst_n = 1; idle();
        for (int i = 0; i < 32; i++) rd(i, 31 - i);
        for (int s = 0; s < 4; s++) rd_csr(s, 3, 3);
        tick(); tick();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog (all requirements): got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule